// File: doc/BRIEF.md
# Sixteen-to-one serializer with exported word clock

The block converts a 16-bit parallel word into a serial bit stream that runs at sixteen times the word rate. A single fast bit clock drives it. All internal registers change on the falling edge of that clock. The fast clock is divided by sixteen inside the block, and the result is driven out as a word clock. The upstream data source is clocked from this word clock, so the serializer, not the source, sets the word timing.

A word is sampled on the fast-clock falling edge that also makes the word clock fall. The word is then shifted out least significant bit first, one bit per fast clock. The next word is loaded on the same edge that retires the last bit of the previous word, so the stream has no idle bits between words. After reset the serial output stays low until the first word has been sampled.

Top module: `ser16_tx`

## Requirements
- R1: Each sampled word leaves `ser_o` over sixteen consecutive fast-clock periods. Bit 0 goes out first and bit 15 goes out last.
- R2: `ser_o` and `word_clk_o` change only on falling edges of `clk_i` or on reset. They hold their value across rising edges.
- R3: `word_clk_o` has a period of sixteen fast-clock periods. It is high for eight and low for eight.
- R4: `par_data_i` is sampled only on the fast falling edge where `word_clk_o` falls. Values present on any other edge have no effect on `ser_o`.
- R5: Bit 0 of a new word appears on `ser_o` in the fast period that directly follows bit 15 of the previous word, with no gap.
- R6: While `rst_ni` is low, `ser_o` is 0 and `word_clk_o` is 1. After release, `ser_o` stays 0 until the first word is sampled.
- R7: The first falling edge of `word_clk_o` after reset release happens on the eighth falling edge of `clk_i`. Later falls follow every sixteen edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast bit clock; state updates on its falling edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| par_data_i | input | 16 | Parallel word, sampled when the word clock falls |
| ser_o | output | 1 | Serial data, bit 0 of each word first |
| word_clk_o | output | 1 | Fast clock divided by sixteen, 8 high / 8 low |

## Verification
Words with a single bit at bit 0 or at bit 15 separate LSB-first order from MSB-first order. Alternating patterns and walking ones expose shifts that are off by one position. All-ones and all-zeros words show whether zero fill or a stale bit leaks in at word boundaries. Between capture edges the inputs are driven with the inverse of the next word, so sampling on the wrong edge shows up at once. A reset in the middle of a frame checks that the divider phase restarts.

// File: rtl/ser16_pkg.sv
package ser16_pkg;
  localparam int unsigned WORD_W_DEF = 16;
endpackage

// File: rtl/ser16_div.sv
module ser16_div #(
  parameter int unsigned WORD_W = ser16_pkg::WORD_W_DEF
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic load_o,
  output logic word_clk_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned HALF  = WORD_W / 2;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);
  localparam logic [CNT_W-1:0] CAP  = CNT_W'(HALF - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wclk_q;

  assign cnt_d = (cnt_q == LAST) ? '0 : cnt_q + 1'b1;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wclk_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_d;
      wclk_q <= (cnt_d < CNT_W'(HALF));  // registered, glitch-free
    end
  end

  assign load_o     = (cnt_q == CAP);
  assign word_clk_o = wclk_q;
endmodule

// File: rtl/ser16_shift.sv
module ser16_shift #(
  parameter int unsigned WORD_W = ser16_pkg::WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] data_i,
  output logic              bit_o
);
  logic [WORD_W-1:0] sh_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= data_i;
    else             sh_q <= {1'b0, sh_q[WORD_W-1:1]};
  end

  assign bit_o = sh_q[0];
endmodule

// File: rtl/ser16_tx.sv
module ser16_tx #(
  parameter int unsigned WORD_W = ser16_pkg::WORD_W_DEF
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [WORD_W-1:0] par_data_i,
  output logic              ser_o,
  output logic              word_clk_o
);
  logic load;

  ser16_div #(.WORD_W(WORD_W)) u_div (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_o     (load),
    .word_clk_o (word_clk_o)
  );

  ser16_shift #(.WORD_W(WORD_W)) u_shift (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .data_i (par_data_i),
    .bit_o  (ser_o)
  );
endmodule

// File: rtl/ser16_chk.sv
module ser16_chk #(
  parameter int unsigned WORD_W = ser16_pkg::WORD_W_DEF
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [WORD_W-1:0] par_data_i,
  input logic              ser_o,
  input logic              word_clk_o
);
  localparam int unsigned CNT_W = $clog2(WORD_W);
  localparam int unsigned HALF  = WORD_W / 2;

  logic [CNT_W-1:0] edges_q;
  logic             seen_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      edges_q <= '0;
      seen_q  <= 1'b0;
    end else begin
      edges_q <= edges_q + 1'b1;
      if (!word_clk_o) seen_q <= 1'b1;
    end
  end

  AST_WCLK_FALL_PHASE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(word_clk_o) |-> edges_q == CNT_W'(HALF));  // R3
  AST_WCLK_RISE_PHASE: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(word_clk_o) |-> edges_q == '0);  // R3
  AST_CAPTURE_ON_FALL: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $fell(word_clk_o) |-> ser_o == $past(par_data_i[0]));  // R4
  AST_IDLE_LOW: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (!seen_q && !$fell(word_clk_o)) |-> !ser_o);  // R6
endmodule

bind ser16_tx ser16_chk #(.WORD_W(WORD_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .par_data_i (par_data_i),
  .ser_o      (ser_o),
  .word_clk_o (word_clk_o)
);

// File: tb/test_ser16_tx.sv
module test_ser16_tx;
  logic        clk = 1'b1;
  logic        rst_n = 1'b1;
  logic [15:0] par = '0;
  logic        ser, wclk;

  int errors = 0, checks = 0;
  bit done = 0;

  int         n;
  int         frame;
  bit         loaded;
  logic [15:0] cur;
  bit         bitq[$];
  logic       exp_ser;

  ser16_tx i_ser16_tx (
    .clk_i(clk), .rst_ni(rst_n), .par_data_i(par), .ser_o(ser), .word_clk_o(wclk)
  );

  always #5 clk = ~clk;

  function automatic logic [15:0] word_of(int k);
    case (k % 8)
      0: return 16'h0001;
      1: return 16'h8000;
      2: return 16'h5555;
      3: return 16'hAAAA;
      4: return 16'hFFFF;
      5: return 16'h0000;
      6: return 16'h0001 << (k % 16);
      default: return 16'((k * 40503) ^ 16'h3C5A);
    endcase
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: act=%b exp=%b at n=%0d", tag, act, exp, n);
    end
  endtask

  task automatic model_reset();
    n = 0; loaded = 0; bitq.delete(); exp_ser = 1'b0;
  endtask

  // one iteration per fast period: model the falling edge just passed, compare, drive next input
  task automatic run_cycles(int cnt);
    for (int c = 0; c < cnt; c++) begin
      logic s1, w1;
      @(posedge clk); #1;
      n++;
      if (n % 16 == 8) begin
        bitq.delete();
        for (int b = 0; b < 16; b++) bitq.push_back(cur[b]);
        loaded = 1;
      end
      exp_ser = (bitq.size() > 0) ? bitq.pop_front() : 1'b0;
      if (!loaded)            chk("R6 idle low", ser, 1'b0);
      else if (n % 16 == 8)   chk("R5 word boundary", ser, exp_ser);
      else if (n % 16 == 9)   chk("R4 off-edge input ignored", ser, exp_ser);
      else                    chk("R1 serial bit", ser, exp_ser);
      if (n == 8) chk("R7 first word clock fall", wclk, 1'b0);
      else        chk("R3 word clock level", wclk, ((n % 16) < 8));
      // next edge is the capture edge only when (n+1)%16==8
      if ((n + 1) % 16 == 8) begin
        cur = word_of(frame); frame++;
      end else begin
        cur = ~word_of(frame);
      end
      par = cur;
      s1 = ser; w1 = wclk;
      #3;
      chk("R2 stable between falling edges", ser, s1);
      chk("R2 word clock stable", wclk, w1);
    end
  endtask

  initial begin
    frame = 0;
    model_reset();
    cur = 16'hFFFF; par = cur;
    #2 rst_n = 1'b0;
    #1;
    chk("R6 reset ser", ser, 1'b0);
    chk("R6 reset word clock", wclk, 1'b1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_reset();
    cur = ~word_of(frame); par = cur;
    #3;
    run_cycles(330);
    // reset in mid-frame
    @(posedge clk); #1;
    rst_n = 1'b0;
    #1;
    chk("R6 mid reset ser", ser, 1'b0);
    chk("R6 mid reset word clock", wclk, 1'b1);
    @(posedge clk); #1;
    rst_n = 1'b1;
    model_reset();
    cur = ~word_of(frame); par = cur;
    #3;
    run_cycles(120);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: act=timeout exp=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule